// File: doc/BRIEF.md
# Streaming WAVE Header Parser

This block accepts an audio file image as a stream of bytes, one byte on each cycle where `in_valid` is high, and converts it into stereo PCM sample pairs. It walks the RIFF container byte by byte. It compares each chunk tag against the expected characters and rebuilds the little-endian numeric fields. It steps over an optional padding chunk and any extra bytes in the format chunk. It stores the sample rate and channel count, and then splits the audio payload into a left and a right signed 24-bit sample for each frame.

The parser only accepts uncompressed, stereo, 24-bit audio. Any other header, and any tag that does not match, sends it to a sticky error state in which it produces no samples. When the last whole frame given by the data size has been emitted, the parser raises `done` and discards every later byte, so metadata after the audio has no effect. A synchronous reset returns it to the start, where it waits for a new container tag. The input never applies back-pressure.

Top module: `wav_stream_parser`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `in_ready` is 1, `smp_valid`, `fmt_err` and `done` are 0, and `smp_left`, `smp_right`, `sample_rate` and `chan_count` are 0.
- R2: The first four bytes must be 0x52,0x49,0x46,0x46. After four size bytes, the next four must be 0x57,0x41,0x56,0x45. A mismatch in either tag sets `fmt_err`.
- R3: At the chunk position after the container tag, a chunk tagged 0x4A,0x55,0x4E,0x4B is skipped: its 4-byte little-endian size gives the number of payload bytes to drop, and that size may be 0. A format tag 0x66,0x6D,0x74,0x20 is accepted directly. Any other tag there sets `fmt_err`.
- R4: The format body is 16 bytes in this order: code (2), channels (2), rate (4), byte rate (4), block align (2), bits per sample (2), all least-significant byte first. `sample_rate` and `chan_count` hold the decoded rate and channel count.
- R5: A format code other than 1, a channel count other than 2, a bits-per-sample value other than 24, or a format chunk size below 16 sets `fmt_err`.
- R6: Each data frame is 6 bytes: the left sample in 3 bytes, least-significant first, then the right sample in the same layout. `smp_left` and `smp_right` change only in a cycle where `smp_valid` is 1.
- R7: `smp_valid` is high for exactly one cycle per frame, in the cycle after the clock edge that accepts the frame's sixth byte.
- R8: The data chunk (tag 0x64,0x61,0x74,0x61, then a 4-byte size) produces floor(size/6) frames. `done` is then raised, and no later byte produces a sample. A size below 6 raises `done` with no frames.
- R9: `fmt_err` stays high until reset. While it is high, no sample is produced and `done` stays low.
- R10: A byte is consumed only on a cycle where `in_valid` is 1. On other cycles the value of `in_byte` has no effect on the parsed result.
- R11: When the format chunk size exceeds 16, the bytes beyond the 16-byte body are skipped before the data tag is expected.
- R12: Asserting `rst` in the middle of a stream restarts the parser, and a complete file sent afterwards parses correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte qualifier |
| in_byte | input | 8 | Stream byte |
| in_ready | output | 1 | Always 1; parser never stalls |
| smp_left | output | 24 | Signed left sample of the last frame |
| smp_right | output | 24 | Signed right sample of the last frame |
| smp_valid | output | 1 | One-cycle strobe per emitted frame |
| sample_rate | output | 32 | Decoded sample rate |
| chan_count | output | 16 | Decoded channel count |
| fmt_err | output | 1 | Sticky header or format error |
| done | output | 1 | All frames of the data chunk emitted |

## Verification
A frame's strobe and both samples appear in the cycle after the edge that accepts its sixth byte. The bench drives inputs on the falling edge and samples outputs on the next falling edge, so each frame is compared exactly once, at the half cycle after the accepting edge. The error and done flags, and the captured rate and channel count, are one register away from the byte that decides them. The bench reads them only after the whole file has been sent and several idle cycles have passed. Random idle gaps with random data on `in_byte` are mixed into the byte stream, so the results also confirm that bytes not marked valid are ignored.

// File: rtl/wsp_pkg.sv
package wsp_pkg;
  localparam int HALF_W    = 16;
  localparam int FMT_BYTES = 16;
  // last byte offset of each decoded field inside the format body
  localparam int OFF_CODE  = 1;
  localparam int OFF_CHAN  = 3;
  localparam int OFF_RATE  = 7;
  localparam int OFF_BITS  = 15;
  localparam int PCM_CODE  = 1;
  localparam int STEREO    = 2;

  // tags as seen after little-endian assembly of four bytes
  localparam logic [31:0] TAG_RIFF = 32'h4646_4952;
  localparam logic [31:0] TAG_WAVE = 32'h4556_4157;
  localparam logic [31:0] TAG_JUNK = 32'h4B4E_554A;
  localparam logic [31:0] TAG_FMT  = 32'h2074_6D66;
  localparam logic [31:0] TAG_DATA = 32'h6174_6164;

  typedef enum logic [3:0] {
    ST_RIFF, ST_RSIZE, ST_WAVE, ST_CHTAG, ST_JSIZE, ST_JSKIP, ST_FSIZE,
    ST_FBODY, ST_FSKIP, ST_DTAG, ST_DSIZE, ST_DATA, ST_DONE, ST_ERR
  } wsp_state_e;
endpackage

// File: rtl/wsp_le_field.sv
module wsp_le_field #(
  parameter int BYTE_W  = 8,
  parameter int FIELD_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               shift_en,
  input  logic [BYTE_W-1:0]  byte_in,
  output logic [FIELD_W-1:0] acc_nxt
);
  logic [FIELD_W-1:0] acc_q;

  // newest byte enters at the top: after N bytes the top N bytes hold the value
  assign acc_nxt = {byte_in, acc_q[FIELD_W-1:BYTE_W]};

  always_ff @(posedge clk) begin
    if (rst)           acc_q <= '0;
    else if (shift_en) acc_q <= acc_nxt;
  end
endmodule

// File: rtl/wsp_down_cnt.sv
module wsp_down_cnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] cnt_q
);
  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (dec)  cnt_q <= cnt_q - W'(1);
  end
endmodule

// File: rtl/wsp_sample_pack.sv
module wsp_sample_pack #(
  parameter int BYTE_W   = 8,
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                shift_en,
  input  logic                hold_left,
  input  logic                emit,
  input  logic [BYTE_W-1:0]   byte_in,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o
);
  logic [SAMPLE_W-1:0] sh_q, left_hold_q, sh_nxt;

  assign sh_nxt = {byte_in, sh_q[SAMPLE_W-1:BYTE_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q        <= '0;
      left_hold_q <= '0;
      left_o      <= '0;
      right_o     <= '0;
      valid_o     <= 1'b0;
    end else begin
      valid_o <= emit;
      if (shift_en)  sh_q        <= sh_nxt;
      if (hold_left) left_hold_q <= sh_nxt;
      if (emit) begin
        left_o  <= left_hold_q;
        right_o <= sh_nxt;
      end
    end
  end
endmodule

// File: rtl/wav_stream_parser.sv
module wav_stream_parser
  import wsp_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int FIELD_W  = 32,
  parameter int SAMPLE_W = 24,
  parameter int CHAN_W   = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [BYTE_W-1:0]   in_byte,
  output logic                in_ready,
  output logic [SAMPLE_W-1:0] smp_left,
  output logic [SAMPLE_W-1:0] smp_right,
  output logic                smp_valid,
  output logic [FIELD_W-1:0]  sample_rate,
  output logic [CHAN_W-1:0]   chan_count,
  output logic                fmt_err,
  output logic                done
);
  localparam int SAMPLE_BYTES = SAMPLE_W / BYTE_W;
  localparam int FRAME_BYTES  = SAMPLE_BYTES * STEREO;
  localparam int FIELD_BYTES  = FIELD_W / BYTE_W;
  localparam int IDX_W        = $clog2(FMT_BYTES);

  wsp_state_e         st_q, st_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [FIELD_W-1:0] rate_q;
  logic [CHAN_W-1:0]  chan_q;
  logic [FIELD_W-1:0] fld_nxt, skip_q, skip_val, rem_q;
  logic [HALF_W-1:0]  half;
  logic               accept, last4, frame_end;
  logic               skip_load, skip_dec, rem_load, rem_dec;
  logic               cap_rate, cap_chan, pk_shift, pk_hold, pk_emit;

  assign accept = in_valid;
  assign half   = fld_nxt[FIELD_W-1 -: HALF_W];
  assign last4  = (idx_q == IDX_W'(FIELD_BYTES - 1));

  wsp_le_field #(.BYTE_W(BYTE_W), .FIELD_W(FIELD_W)) u_fld (
    .clk(clk), .rst(rst), .shift_en(accept), .byte_in(in_byte), .acc_nxt(fld_nxt)
  );

  wsp_down_cnt #(.W(FIELD_W)) u_skip (
    .clk(clk), .rst(rst), .load(skip_load), .load_val(skip_val),
    .dec(skip_dec), .cnt_q(skip_q)
  );

  wsp_down_cnt #(.W(FIELD_W)) u_rem (
    .clk(clk), .rst(rst), .load(rem_load), .load_val(fld_nxt),
    .dec(rem_dec), .cnt_q(rem_q)
  );

  wsp_sample_pack #(.BYTE_W(BYTE_W), .SAMPLE_W(SAMPLE_W)) u_pack (
    .clk(clk), .rst(rst), .shift_en(pk_shift), .hold_left(pk_hold),
    .emit(pk_emit), .byte_in(in_byte),
    .left_o(smp_left), .right_o(smp_right), .valid_o(smp_valid)
  );

  always_comb begin
    st_d      = st_q;
    skip_load = 1'b0;
    skip_val  = '0;
    skip_dec  = 1'b0;
    rem_load  = 1'b0;
    rem_dec   = 1'b0;
    cap_rate  = 1'b0;
    cap_chan  = 1'b0;
    pk_shift  = 1'b0;
    pk_hold   = 1'b0;
    pk_emit   = 1'b0;
    frame_end = 1'b0;
    if (accept) begin
      unique case (st_q)
        ST_RIFF:  if (last4) st_d = (fld_nxt == TAG_RIFF) ? ST_RSIZE : ST_ERR;
        ST_RSIZE: if (last4) st_d = ST_WAVE;
        ST_WAVE:  if (last4) st_d = (fld_nxt == TAG_WAVE) ? ST_CHTAG : ST_ERR;
        ST_CHTAG: if (last4) begin
          if (fld_nxt == TAG_JUNK)     st_d = ST_JSIZE;
          else if (fld_nxt == TAG_FMT) st_d = ST_FSIZE;
          else                         st_d = ST_ERR;
        end
        ST_JSIZE: if (last4) begin
          skip_load = 1'b1;
          skip_val  = fld_nxt;
          st_d      = (fld_nxt == '0) ? ST_CHTAG : ST_JSKIP;
        end
        ST_JSKIP: begin
          skip_dec = 1'b1;
          if (skip_q == FIELD_W'(1)) st_d = ST_CHTAG;
        end
        ST_FSIZE: if (last4) begin
          if (fld_nxt < FIELD_W'(FMT_BYTES)) st_d = ST_ERR;
          else begin
            skip_load = 1'b1;
            skip_val  = fld_nxt - FIELD_W'(FMT_BYTES);
            st_d      = ST_FBODY;
          end
        end
        ST_FBODY: begin
          if (idx_q == IDX_W'(OFF_CODE) && half != HALF_W'(PCM_CODE)) st_d = ST_ERR;
          if (idx_q == IDX_W'(OFF_CHAN)) begin
            cap_chan = 1'b1;
            if (half != HALF_W'(STEREO)) st_d = ST_ERR;
          end
          if (idx_q == IDX_W'(OFF_RATE)) cap_rate = 1'b1;
          if (idx_q == IDX_W'(OFF_BITS)) begin
            if (half != HALF_W'(SAMPLE_W)) st_d = ST_ERR;
            else st_d = (skip_q == '0) ? ST_DTAG : ST_FSKIP;
          end
        end
        ST_FSKIP: begin
          skip_dec = 1'b1;
          if (skip_q == FIELD_W'(1)) st_d = ST_DTAG;
        end
        ST_DTAG:  if (last4) st_d = (fld_nxt == TAG_DATA) ? ST_DSIZE : ST_ERR;
        ST_DSIZE: if (last4) begin
          rem_load = 1'b1;
          st_d     = (fld_nxt < FIELD_W'(FRAME_BYTES)) ? ST_DONE : ST_DATA;
        end
        ST_DATA: begin
          rem_dec  = 1'b1;
          pk_shift = 1'b1;
          if (idx_q == IDX_W'(SAMPLE_BYTES - 1)) pk_hold = 1'b1;
          if (idx_q == IDX_W'(FRAME_BYTES - 1)) begin
            pk_emit   = 1'b1;
            frame_end = 1'b1;
            if (rem_q <= FIELD_W'(FRAME_BYTES)) st_d = ST_DONE;
          end
        end
        default: st_d = st_q;
      endcase
    end
  end

  always_comb begin
    idx_d = idx_q;
    if (accept) idx_d = (st_d != st_q || frame_end) ? '0 : idx_q + IDX_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_RIFF;
      idx_q  <= '0;
      rate_q <= '0;
      chan_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      if (cap_rate) rate_q <= fld_nxt;
      if (cap_chan) chan_q <= CHAN_W'(half);
    end
  end

  assign in_ready    = 1'b1;
  assign sample_rate = rate_q;
  assign chan_count  = chan_q;
  assign fmt_err     = (st_q == ST_ERR);
  assign done        = (st_q == ST_DONE);
endmodule

// File: rtl/wsp_checker.sv
module wsp_checker #(
  parameter int SAMPLE_W = 24
) (
  input logic                clk,
  input logic                rst,
  input logic                smp_valid,
  input logic [SAMPLE_W-1:0] smp_left,
  input logic [SAMPLE_W-1:0] smp_right,
  input logic                fmt_err,
  input logic                done
);
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    smp_valid |=> !smp_valid); // R7
  AST_LEFT_ONLY_ON_VALID: assert property (@(posedge clk) disable iff (rst)
    !$stable(smp_left) |-> smp_valid); // R6
  AST_RIGHT_ONLY_ON_VALID: assert property (@(posedge clk) disable iff (rst)
    !$stable(smp_right) |-> smp_valid); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    fmt_err |=> fmt_err); // R9
  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (rst)
    fmt_err |-> (!smp_valid && !done)); // R9
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    done |=> (done && !smp_valid)); // R8
endmodule

bind wav_stream_parser wsp_checker #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_left(smp_left),
  .smp_right(smp_right), .fmt_err(fmt_err), .done(done)
);

// File: tb/wav_stream_parser_tb.sv
module wav_stream_parser_tb;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = '0;
  logic        in_ready, smp_valid, fmt_err, done;
  logic [23:0] smp_left, smp_right;
  logic [31:0] sample_rate;
  logic [15:0] chan_count;

  int checks = 0, failures = 0;
  logic [7:0]  fbuf [0:2047];
  int          flen;
  logic [23:0] exp_l [0:255];
  logic [23:0] exp_r [0:255];
  int          exp_n, got;
  logic        prev_v;
  logic [23:0] last_l, last_r;

  always #2.5 clk = ~clk;

  wav_stream_parser u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .smp_left(smp_left), .smp_right(smp_right),
    .smp_valid(smp_valid), .sample_rate(sample_rate), .chan_count(chan_count),
    .fmt_err(fmt_err), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put8(input logic [7:0] b);
    fbuf[flen] = b;
    flen++;
  endtask
  task automatic put16(input logic [15:0] v);
    put8(v[7:0]); put8(v[15:8]);
  endtask
  task automatic put32(input logic [31:0] v);
    put16(v[15:0]); put16(v[31:16]);
  endtask
  task automatic puttag(input logic [31:0] t);
    put8(t[31:24]); put8(t[23:16]); put8(t[15:8]); put8(t[7:0]);
  endtask

  task automatic build(input bit junk, input int jlen, input int extra, input int code,
                       input int ch, input int bits, input logic [31:0] rate,
                       input int nfr, input int part, input int trail,
                       input logic [31:0] rtag);
    flen = 0;
    puttag(rtag); put32(32'd1000); puttag(32'h5741_5645);
    if (junk) begin
      puttag(32'h4A55_4E4B); put32(jlen);
      for (int i = 0; i < jlen; i++) put8(8'($urandom));
    end
    puttag(32'h666D_7420); put32(16 + extra);
    put16(code); put16(ch); put32(rate); put32(rate * 6); put16(16'd6); put16(bits);
    for (int i = 0; i < extra; i++) put8(8'($urandom));
    puttag(32'h6461_7461); put32(nfr * 6 + part);
    for (int k = 0; k < nfr; k++) begin
      exp_l[k] = 24'($urandom);
      exp_r[k] = 24'($urandom);
      put8(exp_l[k][7:0]); put8(exp_l[k][15:8]); put8(exp_l[k][23:16]);
      put8(exp_r[k][7:0]); put8(exp_r[k][15:8]); put8(exp_r[k][23:16]);
    end
    for (int i = 0; i < part + trail; i++) put8(8'($urandom));
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    got = 0;
  endtask

  task automatic send(input int limit, input int gap_pct);
    for (int i = 0; i < limit; i++) begin
      while (int'($urandom % 100) < gap_pct) begin
        in_valid = 1'b0;
        in_byte  = 8'($urandom);  // R10: garbage while not valid
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_byte  = fbuf[i];
      @(negedge clk);
    end
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic expect_ok(input string name, input logic [31:0] rate);
    chk(got == exp_n, {name, " R8 frame count"}, got, exp_n);
    chk(done == 1'b1, {name, " R8 done"}, done, 1);
    chk(fmt_err == 1'b0, {name, " R2 no error"}, fmt_err, 0);
    chk(sample_rate == rate, {name, " R4 rate"}, sample_rate, rate);
    chk(chan_count == 16'd2, {name, " R4 channels"}, chan_count, 2);
  endtask

  task automatic expect_err(input string name, input string req);
    chk(fmt_err == 1'b1, {name, " ", req, " error flag"}, fmt_err, 1);
    chk(got == 0, {name, " R9 no samples"}, got, 0);
    chk(done == 1'b0, {name, " R9 done low"}, done, 0);
  endtask

  // monitor: compare frames one half cycle after the accepting edge
  always @(negedge clk) begin
    if (!rst) begin
      if (smp_valid) begin
        chk(!prev_v, "R7 strobe single cycle", prev_v, 0);
        if (got < exp_n) begin
          chk(smp_left == exp_l[got], "R6 left sample", smp_left, exp_l[got]);
          chk(smp_right == exp_r[got], "R6 right sample", smp_right, exp_r[got]);
        end else chk(1'b0, "R8 extra frame", got, exp_n);
        got++;
      end else if (smp_left !== last_l || smp_right !== last_r) begin
        chk(1'b0, "R6 output changed without strobe", smp_left, last_l);
      end
    end
    prev_v = smp_valid;
    last_l = smp_left;
    last_r = smp_right;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd1357));
    got = 0; exp_n = 0;
    repeat (3) @(negedge clk);
    // R1: state during reset
    chk(in_ready == 1'b1, "R1 ready in reset", in_ready, 1);
    chk({smp_valid, fmt_err, done} == 3'b000, "R1 flags in reset", {smp_valid, fmt_err, done}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(smp_left == 0 && smp_right == 0, "R1 samples zero", smp_left, 0);
    chk(sample_rate == 0 && chan_count == 0, "R1 fields zero", sample_rate, 0);

    // R3 with padding chunk, R8 partial frame and trailing metadata
    do_reset(); exp_n = 10;
    build(1, 5, 0, 1, 2, 24, 32'd48000, 10, 4, 20, 32'h5249_4646);
    send(flen, 0); expect_ok("c1", 32'd48000);

    // R11 oversized format chunk, no padding chunk, R10 random gaps
    do_reset(); exp_n = 7; r = $urandom;
    build(0, 0, 2, 1, 2, 24, r, 7, 0, 9, 32'h5249_4646);
    send(flen, 40); expect_ok("c2", r);

    // R5 bad format code, bad bits, bad channel count
    do_reset(); exp_n = 0;
    build(0, 0, 0, 3, 2, 24, 32'd44100, 3, 0, 0, 32'h5249_4646);
    send(flen, 10); expect_err("c3", "R5");
    do_reset();
    build(1, 3, 0, 1, 2, 16, 32'd44100, 3, 0, 0, 32'h5249_4646);
    send(flen, 10); expect_err("c4", "R5");
    do_reset();
    build(0, 0, 0, 1, 1, 24, 32'd44100, 3, 0, 0, 32'h5249_4646);
    send(flen, 10); expect_err("c5", "R5");

    // R2 bad container tag
    do_reset();
    build(0, 0, 0, 1, 2, 24, 32'd44100, 3, 0, 0, 32'h5249_4647);
    send(flen, 0); expect_err("c6", "R2");

    // R12 reset in the middle of a file
    do_reset(); exp_n = 5; r = $urandom;
    build(1, 2, 0, 1, 2, 24, r, 5, 1, 6, 32'h5249_4646);
    send(70, 20);
    do_reset();
    send(flen, 20); expect_ok("c7 R12", r);

    // R8 empty data chunk, R3 zero-length padding chunk
    do_reset(); exp_n = 0;
    build(1, 0, 0, 1, 2, 24, 32'd96000, 0, 3, 12, 32'h5249_4646);
    send(flen, 0); expect_ok("c8", 32'd96000);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule